// File: doc/BRIEF.md
# SPI Register-Access Slave with Selectable Duplex Wiring

This block is an SPI slave front end. An external master uses it to read and write a bank of 21 byte-wide registers. One configuration input chooses the wiring at run time. In full-duplex wiring, command and write data arrive on a dedicated input and read data leaves on a dedicated output, which is tri-stated whenever slave select is high. In half-duplex wiring, one shared data pin carries both directions. The block turns that pin around to drive read data once the command byte is complete, and releases it when slave select rises. The shared pin is presented as a split pad (input, output, output enable), so the tri-state buffer sits outside the core.

Every transaction starts with a command byte that names a register and a direction. Data bytes follow. Addresses 0 to 4 are not storage: they are ports onto five endpoint FIFOs that live outside the block. Each whole data byte written to one of these addresses gives a push strobe, and each whole data byte read from one gives a pop strobe. The address stays put, so a burst streams through a single FIFO. Addresses 5 to 20 are plain registers, and the address advances after every byte of a burst.

The serial inputs are oversampled by the block clock through synchronizers. SCLK must therefore stay at each level for at least four clock cycles.

Top module: `spi_regif_duplex`

## Requirements
- R1: With `full_duplex_i`=1, serial data is taken from `mosi_i` and returned on `miso_o`, and `sio_i` is ignored. With `full_duplex_i`=0, serial data is taken from `sio_i` and returned on `sio_o`, and `mosi_i` is ignored.
- R2: The first eight SCLK rising edges after slave select falls shift in the command byte, MSB first. Bits 7:3 are the register address. Bit 1 is the direction, where 1 means write and 0 means read. Bits 2 and 0 have no effect.
- R3: The block uses SPI mode 0. Input bits are sampled on SCLK rising edges and output bits change on SCLK falling edges, MSB first. The MSB of the first read byte is valid after the eighth falling edge of the command byte.
- R4: Addresses 5 to 20 are read/write byte registers that reset to 0x00. A write followed by a read returns the value written.
- R5: Writes to addresses 21 to 31 change nothing, and reads from them return 0x00.
- R6: Within one slave-select assertion, the address advances by one after each whole data byte when it is 5 or higher. This holds for both writes and reads.
- R7: A whole data byte written to address 0 to 4 gives one `fifo_push_o` pulse, with `fifo_sel_o` equal to the address and `fifo_wdata_o` equal to the byte. The address does not advance.
- R8: When reading address 0 to 4, each byte is loaded from `fifo_rdata_i`, and each whole data byte gives one `fifo_pop_o` pulse. A burst therefore returns successive FIFO entries in order.
- R9: `sio_oe_o` is 0 during the command byte. For a half-duplex read it is 1 from the eighth SCLK falling edge until slave select rises. It stays 0 for writes and in full-duplex wiring.
- R10: `miso_oe_o` is 1 only in full-duplex wiring while slave select is low. It is 0 in half-duplex wiring.
- R11: Raising slave select before the eighth bit of a data byte abandons that byte. No register changes and no push or pop occurs.
- R12: After reset both output enables are 0 and no push or pop strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_duplex_i | input | 1 | 1: separate data in/out pins, 0: shared data pin |
| sclk_i | input | 1 | SPI serial clock |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data in, full-duplex wiring |
| miso_o | output | 1 | Serial data out, full-duplex wiring |
| miso_oe_o | output | 1 | Output enable for miso_o |
| sio_i | input | 1 | Shared data pin, input side |
| sio_o | output | 1 | Shared data pin, output side |
| sio_oe_o | output | 1 | Shared data pin output enable |
| fifo_sel_o | output | 3 | FIFO index for the current access |
| fifo_push_o | output | 1 | One-cycle push strobe |
| fifo_wdata_o | output | 8 | Data for the push |
| fifo_pop_o | output | 1 | One-cycle pop strobe |
| fifo_rdata_i | input | 8 | Head entry of the selected FIFO |

## Verification
A vector table writes and reads registers at the bottom, middle and top of the storage range, and just past its end, switching wiring between the write and the read-back. This shows that both wirings reach the same storage. The idle data pin of each wiring is always driven with the inverse of the real bit, so any leak from it shows up as a corrupted byte. Directed transactions cover several further cases:
- a command with its ignored bits set;
- three-byte bursts that tell address advance apart from FIFO streaming, checked by push count, pop count and order;
- the output-enable timing sampled before and after the eighth falling edge;
- transfers cut mid-byte, both to a register and to a FIFO.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 5;
  localparam int CMD_ADDR_LSB = 3;
  localparam int CMD_WR_BIT   = 1;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_WR,
    PH_RD
  } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DW = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  ss_ni,
  input  logic                  din_i,
  input  logic                  load_i,
  input  logic [DW-1:0]         load_data_i,
  output logic                  fall_o,
  output logic [$clog2(DW)-1:0] bit_cnt_o,
  output logic                  byte_done_o,
  output logic [DW-1:0]         byte_o,
  output logic                  dout_o
);
  localparam int CW = $clog2(DW);

  logic          sclk_q;
  logic          active;
  logic          rise;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rx_q;
  logic [DW-1:0] tx_q;

  assign active      = ~ss_ni;
  assign rise        = sclk_i & ~sclk_q & active;
  assign fall_o      = ~sclk_i & sclk_q & active;
  assign byte_done_o = rise && (cnt_q == CW'(DW - 1));
  assign byte_o      = {rx_q[DW-2:0], din_i};
  assign bit_cnt_o   = cnt_q;
  assign dout_o      = tx_q[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (!active) begin
        // deselect discards any partial byte
        cnt_q <= '0;
        rx_q  <= '0;
        tx_q  <= '0;
      end else begin
        if (rise) begin
          cnt_q <= byte_done_o ? '0 : cnt_q + 1'b1;
          rx_q  <= {rx_q[DW-2:0], din_i};
        end
        if (fall_o) tx_q <= load_i ? load_data_i : {tx_q[DW-2:0], 1'b0};
      end
    end
  end

  assert_bit_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !byte_done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_abort_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (cnt_q == '0));
endmodule

// File: rtl/spi_reg_store.sv
module spi_reg_store #(
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int NUM_REGS = 21,
  parameter int NUM_FIFO = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] fifo_rdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int NUM_STORE = NUM_REGS - NUM_FIFO;

  logic [NUM_STORE-1:0][DW-1:0] store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_STORE; i++)
        if (addr_i == AW'(NUM_FIFO + i)) store_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < AW'(NUM_FIFO)) begin
      rdata_o = fifo_rdata_i;
    end else begin
      for (int i = 0; i < NUM_STORE; i++)
        if (addr_i == AW'(NUM_FIFO + i)) rdata_o = store_q[i];
    end
  end

  assert_unmapped_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i >= AW'(NUM_REGS)) |=> $stable(store_q));
endmodule

// File: rtl/spi_regif_duplex.sv
module spi_regif_duplex
  import spi_regif_pkg::*;
#(
  parameter int NUM_REGS    = 21,
  parameter int NUM_FIFO    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        full_duplex_i,
  input  logic                        sclk_i,
  input  logic                        ss_ni,
  input  logic                        mosi_i,
  output logic                        miso_o,
  output logic                        miso_oe_o,
  input  logic                        sio_i,
  output logic                        sio_o,
  output logic                        sio_oe_o,
  output logic [$clog2(NUM_FIFO)-1:0] fifo_sel_o,
  output logic                        fifo_push_o,
  output logic [DATA_W-1:0]           fifo_wdata_o,
  output logic                        fifo_pop_o,
  input  logic [DATA_W-1:0]           fifo_rdata_i
);
  localparam int FW = $clog2(NUM_FIFO);
  localparam int CW = $clog2(DATA_W);

  logic              sclk_s, ss_s, din_s;
  logic              eng_fall, eng_done, eng_dout, load_rd;
  logic [CW-1:0]     eng_cnt;
  logic [DATA_W-1:0] eng_byte, rd_data;
  logic              reg_wr, is_fifo;

  phase_e            phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic              hd_oe_q, push_q, pop_q;
  logic [DATA_W-1:0] wdata_q;

  // data pin chosen by wiring mode before synchronization
  spi_pin_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, ss_ni, (full_duplex_i ? mosi_i : sio_i)}),
    .q_o   ({sclk_s, ss_s, din_s})
  );

  assign load_rd = (phase_q == PH_RD) && (eng_cnt == '0);

  spi_bit_engine #(.DW(DATA_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_s),
    .ss_ni      (ss_s),
    .din_i      (din_s),
    .load_i     (load_rd),
    .load_data_i(rd_data),
    .fall_o     (eng_fall),
    .bit_cnt_o  (eng_cnt),
    .byte_done_o(eng_done),
    .byte_o     (eng_byte),
    .dout_o     (eng_dout)
  );

  assign is_fifo = addr_q < ADDR_W'(NUM_FIFO);
  assign reg_wr  = eng_done && (phase_q == PH_WR) && !is_fifo;

  spi_reg_store #(
    .DW      (DATA_W),
    .AW      (ADDR_W),
    .NUM_REGS(NUM_REGS),
    .NUM_FIFO(NUM_FIFO)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (reg_wr),
    .addr_i      (addr_q),
    .wdata_i     (eng_byte),
    .fifo_rdata_i(fifo_rdata_i),
    .rdata_o     (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      addr_q  <= '0;
      hd_oe_q <= 1'b0;
      push_q  <= 1'b0;
      pop_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      push_q <= 1'b0;
      pop_q  <= 1'b0;
      if (ss_s) begin
        phase_q <= PH_CMD;
        hd_oe_q <= 1'b0;
      end else begin
        if (eng_fall && load_rd) hd_oe_q <= 1'b1;
        if (eng_done) begin
          unique case (phase_q)
            PH_CMD: begin
              addr_q  <= eng_byte[CMD_ADDR_LSB +: ADDR_W];
              phase_q <= eng_byte[CMD_WR_BIT] ? PH_WR : PH_RD;
            end
            PH_WR: begin
              if (is_fifo) begin
                push_q  <= 1'b1;
                wdata_q <= eng_byte;
              end else begin
                addr_q <= addr_q + 1'b1;
              end
            end
            PH_RD: begin
              if (is_fifo) pop_q <= 1'b1;
              else         addr_q <= addr_q + 1'b1;
            end
            default: phase_q <= PH_CMD;
          endcase
        end
      end
    end
  end

  assign miso_o       = eng_dout;
  assign miso_oe_o    = full_duplex_i & ~ss_s;
  assign sio_o        = eng_dout;
  assign sio_oe_o     = hd_oe_q & ~full_duplex_i;
  assign fifo_sel_o   = is_fifo ? addr_q[FW-1:0] : '0;
  assign fifo_push_o  = push_q;
  assign fifo_pop_o   = pop_q;
  assign fifo_wdata_o = wdata_q;

  assert_pin_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_s |=> !hd_oe_q);

  assert_turnaround_on_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hd_oe_q) |-> $past(phase_q == PH_RD));

  assert_fifo_index_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_push_o || fifo_pop_o) |-> (fifo_sel_o < FW'(NUM_FIFO)));

  assert_push_pop_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_push_o && fifo_pop_o));

  assert_idle_no_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_s && $past(ss_s)) |-> (!fifo_push_o && !fifo_pop_o));
endmodule

// File: tb/tb_spi_regif_duplex.sv
module tb_spi_regif_duplex;
  localparam int HP = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       full_duplex_i = 1'b1;
  logic       sclk_i = 1'b0;
  logic       ss_ni = 1'b1;
  logic       mosi_i = 1'b0;
  logic       sio_drv = 1'b0;
  logic       miso_o, miso_oe_o, sio_o, sio_oe_o, sio_i;
  logic [2:0] fifo_sel_o;
  logic       fifo_push_o, fifo_pop_o;
  logic [7:0] fifo_wdata_o, fifo_rdata_i;

  always #4 clk = ~clk;

  assign sio_i = sio_oe_o ? sio_o : sio_drv;

  spi_regif_duplex dut (
    .clk_i(clk), .rst_ni(rst_ni), .full_duplex_i(full_duplex_i),
    .sclk_i(sclk_i), .ss_ni(ss_ni), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .sio_i(sio_i), .sio_o(sio_o), .sio_oe_o(sio_oe_o),
    .fifo_sel_o(fifo_sel_o), .fifo_push_o(fifo_push_o),
    .fifo_wdata_o(fifo_wdata_o), .fifo_pop_o(fifo_pop_o),
    .fifo_rdata_i(fifo_rdata_i)
  );

  // external FIFO model
  logic [7:0] fmem [8][16];
  logic [3:0] fwr [8];
  logic [3:0] frd [8];
  assign fifo_rdata_i = fmem[fifo_sel_o][frd[fifo_sel_o]];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) begin fwr[i] <= '0; frd[i] <= '0; end
    end else begin
      if (fifo_push_o) begin
        fmem[fifo_sel_o][fwr[fifo_sel_o]] <= fifo_wdata_o;
        fwr[fifo_sel_o] <= fwr[fifo_sel_o] + 1'b1;
      end
      if (fifo_pop_o) frd[fifo_sel_o] <= frd[fifo_sel_o] + 1'b1;
    end
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];
  logic oe_cmd, oe_dat, oe_fd;
  int   push_cnt, pop_cnt;

  always @(posedge clk) begin
    if (fifo_push_o) push_cnt++;
    if (fifo_pop_o)  pop_cnt++;
  end

  // {fd, wr, pad, addr[4:0], data, expected}
  localparam logic [23:0] VECS [11] = '{
    {1'b1, 1'b1, 1'b0, 5'd5,  8'hA5, 8'h00},
    {1'b0, 1'b0, 1'b0, 5'd5,  8'h00, 8'hA5},
    {1'b0, 1'b1, 1'b0, 5'd20, 8'h3C, 8'h00},
    {1'b1, 1'b0, 1'b0, 5'd20, 8'h00, 8'h3C},
    {1'b1, 1'b1, 1'b0, 5'd12, 8'hC3, 8'h00},
    {1'b0, 1'b0, 1'b0, 5'd12, 8'h00, 8'hC3},
    {1'b0, 1'b1, 1'b0, 5'd21, 8'hFF, 8'h00},
    {1'b1, 1'b0, 1'b0, 5'd21, 8'h00, 8'h00},
    {1'b1, 1'b0, 1'b0, 5'd6,  8'h00, 8'h00},
    {1'b0, 1'b1, 1'b0, 5'd31, 8'h77, 8'h00},
    {1'b0, 1'b0, 1'b0, 5'd31, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd(input logic [4:0] a, input logic wr);
    return {a, 1'b0, wr, 1'b0};
  endfunction

  task automatic xfer(input logic fd, input int nbits);
    @(negedge clk);
    full_duplex_i = fd;
    ss_ni = 1'b0;
    repeat (6) @(negedge clk);
    oe_fd = miso_oe_o;
    for (int b = 0; b < nbits; b++) begin
      logic d;
      d = tx_buf[b/8][7-(b%8)];
      mosi_i  = fd ? d : ~d;
      sio_drv = fd ? ~d : d;
      repeat (HP) @(negedge clk);
      rx_buf[b/8][7-(b%8)] = fd ? miso_o : sio_o;
      if (b == 7) oe_cmd = sio_oe_o;
      if (b == 8) oe_dat = sio_oe_o;
      sclk_i = 1'b1;
      repeat (HP) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (HP) @(negedge clk);
    ss_ni = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    push_cnt = 0;
    pop_cnt  = 0;
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12 miso_oe", miso_oe_o, 0);
    check("R12 sio_oe", sio_oe_o, 0);
    check("R12 strobes", {fifo_push_o, fifo_pop_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: R1 R3 R4 R5
    for (int i = 0; i < 11; i++) begin
      logic [23:0] v;
      v = VECS[i];
      tx_buf[0] = cmd(v[20:16], v[22]);
      tx_buf[1] = v[22] ? v[15:8] : 8'h00;
      xfer(v[23], 16);
      if (!v[22]) check($sformatf("R1/R3/R4/R5 vec%0d", i), rx_buf[1], v[7:0]);
    end

    // R2 ignored command bits
    tx_buf[0] = cmd(5'd9, 1'b1) | 8'h05; tx_buf[1] = 8'h5A;
    xfer(1'b1, 16);
    tx_buf[0] = cmd(5'd9, 1'b0) | 8'h05; tx_buf[1] = 8'h00;
    xfer(1'b0, 16);
    check("R2 ignored bits", rx_buf[1], 8'h5A);

    // R6 auto-increment burst write and reads
    tx_buf[0] = cmd(5'd14, 1'b1);
    tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33;
    xfer(1'b0, 32);
    check("R6 no push on reg burst", push_cnt, 0);
    tx_buf[0] = cmd(5'd16, 1'b0); tx_buf[1] = 8'h00;
    xfer(1'b1, 16);
    check("R6 third byte at 16", rx_buf[1], 8'h33);
    tx_buf[0] = cmd(5'd14, 1'b0); tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    xfer(1'b1, 32);
    check("R6 burst read", {rx_buf[1], rx_buf[2], rx_buf[3]}, 24'h112233);
    check("R10 miso_oe in fd", oe_fd, 1'b1);
    check("R9 sio_oe off in fd", oe_dat, 1'b0);
    check("R10 miso_oe after ss", miso_oe_o, 1'b0);

    // R7 FIFO write burst
    tx_buf[0] = cmd(5'd2, 1'b1);
    tx_buf[1] = 8'hAA; tx_buf[2] = 8'hBB; tx_buf[3] = 8'hCC;
    xfer(1'b0, 32);
    check("R7 push count", fwr[2], 3);
    check("R7 fifo contents", {fmem[2][0], fmem[2][1], fmem[2][2]}, 24'hAABBCC);
    check("R9 sio_oe off on write", oe_dat, 1'b0);

    // R8 FIFO read burst in half duplex, R9 turnaround timing
    tx_buf[0] = cmd(5'd2, 1'b0); tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    xfer(1'b0, 32);
    check("R8 fifo read order", {rx_buf[1], rx_buf[2], rx_buf[3]}, 24'hAABBCC);
    check("R8 pop count", frd[2], 3);
    check("R9 sio_oe during cmd", oe_cmd, 1'b0);
    check("R9 sio_oe after 8th fall", oe_dat, 1'b1);
    check("R9 sio_oe released", sio_oe_o, 1'b0);
    check("R10 miso_oe in hd", oe_fd, 1'b0);

    // R11 abort mid-byte: register, FIFO push, FIFO pop
    tx_buf[0] = cmd(5'd5, 1'b1); tx_buf[1] = 8'h0F;
    xfer(1'b1, 12);
    tx_buf[0] = cmd(5'd5, 1'b0); tx_buf[1] = 8'h00;
    xfer(1'b1, 16);
    check("R11 reg unchanged", rx_buf[1], 8'hA5);
    push_cnt = 0;
    tx_buf[0] = cmd(5'd1, 1'b1); tx_buf[1] = 8'hF0;
    xfer(1'b0, 12);
    check("R11 no push", push_cnt, 0);
    tx_buf[0] = cmd(5'd0, 1'b1); tx_buf[1] = 8'h42;
    xfer(1'b1, 16);
    pop_cnt = 0;
    tx_buf[0] = cmd(5'd0, 1'b0); tx_buf[1] = 8'h00;
    xfer(1'b1, 12);
    check("R11 no pop", pop_cnt, 0);
    tx_buf[0] = cmd(5'd0, 1'b0); tx_buf[1] = 8'h00;
    xfer(1'b1, 16);
    check("R8 fifo0 head after abort", rx_buf[1], 8'h42);

    finish_run();
  end
endmodule